// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives one pulse-width-modulated output with 10 bits of duty resolution. An 8-bit timer counts up to a programmable period value. Below it, a 2-bit sub-count splits each timer step into four phases. The timer and the sub-count together form a 10-bit time base. Each period starts with the output high. The output drops when the time base reaches the active duty value.

Software programs the block through a one-cycle register write port. It can write the period, the upper eight duty bits and a control word at any time. The control word holds the lower two duty bits, the run enable and the prescale select. The comparator never uses the written duty value directly. It works from a shadow copy, and the shadow copy is reloaded only when a new period begins. This keeps every period clean when software updates the duty mid-period. A zero duty keeps the output low for the whole period. A duty that reaches past the end of the period keeps the output high for the whole period.

Top module: `pwm10_gen`

## Requirements
- R1: After reset, and whenever the run enable is 0, the output is 0, even if the period and duty registers are written.
- R2: While running, a period lasts (P+1)*4*N clocks, where P is the period register and N is the prescale factor. When the active duty is nonzero, the output is 1 in the first clock of every period, including a period value of 0.
- R3: The active duty D is {upper duty register, control bits 5:4}. The output stays 1 for exactly D*N clocks from the start of the period. This includes D=1023 with P=255, which gives one low clock per period.
- R4: Control bits 1:0 select the prescale factor N: 00 gives 1, 01 gives 4, and 10 or 11 give 16. The sub-count is the two most significant bits of the prescale divider.
- R5: A write to the duty registers during a period does not change the output in that period. The new value takes effect from the next period start.
- R6: When the active duty is 0, the output stays 0 for the whole period.
- R7: When the active duty is at least 4*(P+1), the output stays 1 for the whole period.
- R8: A control write with the enable bit (bit 2) at 0 drives the output to 0 from the next clock, and the output stays 0.
- R9: A control write that sets the enable bit while the block is stopped starts the first period in the next clock. The shadow duty is loaded at that moment, and it includes the lower duty bits carried by that same write.
- Register addresses: 0 is the period, 1 is the upper duty, 2 is the control word, and 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
A control write that starts the block shows up on the output in the clock right after the write edge. A control write that stops it does the same. A duty edge falls in the first clock in which the time base equals the shadow duty. A reloaded duty first shows in the clock after the period-boundary edge. For every clock of a case, the driver queues one expected output level, computed from the period length (P+1)*4*N and the high time D*N. It queues these levels right after the enabling write edge. The monitor pops one entry per clock, one time unit after the falling edge. Each comparison therefore lands on the registered output of the clock it describes. Mid-period writes are scheduled at known clock indices, so the model knows in which period the new duty applies.

// File: rtl/pwm10_pkg.sv
// pwm10_pkg: register map, control bit positions and time-base constants
// shared by the PWM generator modules. Assumes an 8-bit-or-wider write bus.
package pwm10_pkg;

    typedef enum logic [1:0] {
        ADDR_PERIOD  = 2'd0,
        ADDR_DUTY_HI = 2'd1,
        ADDR_CTRL    = 2'd2,
        ADDR_SPARE   = 2'd3
    } reg_addr_e;

    localparam int CTRL_EN_BIT  = 2;   // run enable
    localparam int CTRL_DLO_BIT = 4;   // lower duty bits start here (two bits)
    localparam int SUB_W        = 2;   // sub-count width
    localparam int MAX_PRE_LOG2 = 4;   // largest prescale is 16
    localparam int DIV_W        = SUB_W + MAX_PRE_LOG2;

    // Prescale select to log2 of the prescale factor: 00->1, 01->4, 1x->16
    function automatic logic [2:0] pre_log2(input logic [1:0] sel);
        case (sel)
            2'b00:   return 3'd0;
            2'b01:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pwm10_regs.sv
// pwm10_regs: software-visible registers (period, upper duty, control).
// It also gives the duty value as it stands after the current edge, so a
// write and a reload in the same clock see the newest data. It flags the
// start (enable rising) and stop (enable written 0) events.
// Assumes one write per clock and that TMR_W is at least 6.
module pwm10_regs
    import pwm10_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [1:0]             wr_addr,
    input  logic [TMR_W-1:0]       wr_data,
    output logic [TMR_W-1:0]       period,
    output logic [TMR_W+SUB_W-1:0] duty_nxt,
    output logic                   run,
    output logic [1:0]             psel,
    output logic                   start,
    output logic                   stop
);
    logic             wr_per, wr_dhi, wr_ctl;
    logic [TMR_W-1:0] per_q, dhi_q;
    logic [SUB_W-1:0] dlo_q;
    logic             en_q;
    logic [1:0]       psel_q;

    // Decode the addressed register for this clock's write
    always_comb begin
        wr_per = wr_en && (wr_addr == ADDR_PERIOD);
        wr_dhi = wr_en && (wr_addr == ADDR_DUTY_HI);
        wr_ctl = wr_en && (wr_addr == ADDR_CTRL);
    end

    // Register storage, updated on a decoded write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q  <= '0;
            dhi_q  <= '0;
            dlo_q  <= '0;
            en_q   <= 1'b0;
            psel_q <= 2'b00;
        end else begin
            if (wr_per) per_q <= wr_data;
            if (wr_dhi) dhi_q <= wr_data;
            if (wr_ctl) begin
                dlo_q  <= wr_data[CTRL_DLO_BIT +: SUB_W];
                en_q   <= wr_data[CTRL_EN_BIT];
                psel_q <= wr_data[1:0];
            end
        end
    end

    // Duty value including any write landing on this edge
    always_comb begin
        duty_nxt = {wr_dhi ? wr_data : dhi_q,
                    wr_ctl ? wr_data[CTRL_DLO_BIT +: SUB_W] : dlo_q};
    end

    assign period = per_q;
    assign run    = en_q;
    assign psel   = psel_q;
    assign start  = wr_ctl && wr_data[CTRL_EN_BIT] && !en_q;
    assign stop   = wr_ctl && !wr_data[CTRL_EN_BIT];

endmodule

// File: rtl/pwm10_timebase.sv
// pwm10_timebase: prescale divider and period timer. The divider counts
// 4*N clocks per timer step, and its top two active bits form the sub-count.
// The timer wraps to zero after the step in which it equals the period.
// Both counters are held at zero while stopped. Also provides the
// time-base value that the next edge will produce, for exact compares.
module pwm10_timebase
    import pwm10_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic [1:0]             psel,
    input  logic [TMR_W-1:0]       period,
    output logic [TMR_W-1:0]       tmr,
    output logic [SUB_W-1:0]       sub,
    output logic                   wrap,
    output logic [TMR_W+SUB_W-1:0] nxt_tb
);
    localparam logic [2:0] MAXL = 3'(MAX_PRE_LOG2);

    logic [DIV_W-1:0] div_q, div_nx, lim;
    logic [TMR_W-1:0] tmr_q, tmr_nx;
    logic [2:0]       shft;
    logic             term;

    // Divider limit and step detection for the selected prescale
    always_comb begin
        shft = pre_log2(psel);
        lim  = {DIV_W{1'b1}} >> (MAXL - shft);
        term = (div_q == lim);
        wrap = run && term && (tmr_q == period);
    end

    // Next-state values for the divider and the timer
    always_comb begin
        div_nx = term ? '0 : div_q + 1'b1;
        if (wrap)      tmr_nx = '0;
        else if (term) tmr_nx = tmr_q + 1'b1;
        else           tmr_nx = tmr_q;
        nxt_tb = {tmr_nx, SUB_W'(div_nx >> shft)};
    end

    // Counter registers, cleared while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
            tmr_q <= '0;
        end else begin
            div_q <= div_nx;
            tmr_q <= tmr_nx;
        end
    end

    assign tmr = tmr_q;
    assign sub = SUB_W'(div_q >> shft);

endmodule

// File: rtl/pwm10_duty.sv
// pwm10_duty: shadow duty register and output set/reset latch. At start or
// period wrap it loads the shadow and sets the output unless the new duty is
// zero. It clears the output on the edge that brings the time base to the
// shadow value. A stop write forces the output low before anything else.
module pwm10_duty #(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              start,
    input  logic              stop,
    input  logic              wrap,
    input  logic [DUTY_W-1:0] duty_nxt,
    input  logic [DUTY_W-1:0] nxt_tb,
    output logic              pwm,
    output logic [DUTY_W-1:0] shadow
);
    logic              out_q;
    logic [DUTY_W-1:0] shd_q;

    // Shadow reload and output latch, with stop taking priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            shd_q <= '0;
        end else if (stop) begin
            out_q <= 1'b0;
        end else if (start || wrap) begin
            shd_q <= duty_nxt;
            out_q <= (duty_nxt != '0);
        end else if (run && (nxt_tb == shd_q)) begin
            out_q <= 1'b0;
        end
    end

    assign pwm    = out_q;
    assign shadow = shd_q;

endmodule

// File: rtl/pwm10_gen.sv
// pwm10_gen: top of the double-buffered 10-bit PWM generator. Connects the
// register file, the time base and the shadow/output stage. Assumes a
// single clock domain and synchronous active-low reset.
module pwm10_gen
    import pwm10_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [TMR_W-1:0] wr_data,
    output logic             pwm_out
);
    localparam int DUTY_W = TMR_W + SUB_W;

    logic [TMR_W-1:0]  period_w, tmr_q;
    logic [DUTY_W-1:0] duty_nxt_w, nxt_tb_w, shadow_q;
    logic [SUB_W-1:0]  sub_w;
    logic [1:0]        psel_w;
    logic              en_q, start_w, stop_w, wrap_w;

    pwm10_regs #(.TMR_W(TMR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .period   (period_w),
        .duty_nxt (duty_nxt_w),
        .run      (en_q),
        .psel     (psel_w),
        .start    (start_w),
        .stop     (stop_w)
    );

    pwm10_timebase #(.TMR_W(TMR_W)) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (en_q),
        .psel   (psel_w),
        .period (period_w),
        .tmr    (tmr_q),
        .sub    (sub_w),
        .wrap   (wrap_w),
        .nxt_tb (nxt_tb_w)
    );

    pwm10_duty #(.DUTY_W(DUTY_W)) u_duty (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (en_q),
        .start    (start_w),
        .stop     (stop_w),
        .wrap     (wrap_w),
        .duty_nxt (duty_nxt_w),
        .nxt_tb   (nxt_tb_w),
        .pwm      (pwm_out),
        .shadow   (shadow_q)
    );

endmodule

// File: rtl/pwm10_gen_chk.sv
// pwm10_gen_chk: property checker bound to pwm10_gen. It watches the
// write port, the output, and the timer, sub-count, shadow and run state.
module pwm10_gen_chk
    import pwm10_pkg::*;
#(
    parameter int TMR_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [1:0]             wr_addr,
    input logic [TMR_W-1:0]       wr_data,
    input logic                   pwm_out,
    input logic                   run,
    input logic [TMR_W-1:0]       tmr,
    input logic [SUB_W-1:0]       sub,
    input logic [TMR_W+SUB_W-1:0] shadow
);
    // R1: stopped block keeps the output low
    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pwm_out);

    // R2: the output only rises at time base zero
    p_rise_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> (tmr == '0 && sub == '0));

    // R3: a falling edge while running sits on the shadow duty value
    p_fall_at_duty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwm_out) && run) |-> ({tmr, sub} == shadow));

    // R5: the shadow changes only at a period start
    p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$stable(shadow)) |-> (tmr == '0 && sub == '0));

    // R6: zero shadow duty means a low output
    p_zero_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && shadow == '0) |-> !pwm_out);

    // R8: a control write with enable clear forces the output low next clock
    p_ctrl_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL && !wr_data[CTRL_EN_BIT]) |=> !pwm_out);

endmodule

bind pwm10_gen pwm10_gen_chk #(.TMR_W(TMR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_out (pwm_out),
    .run     (en_q),
    .tmr     (tmr_q),
    .sub     (sub_w),
    .shadow  (shadow_q)
);

// File: tb/sim_pwm10_gen.sv
// sim_pwm10_gen: scoreboard bench. A driver queues one expected output level
// per clock of each case, and a monitor pops and compares them each clock.
module sim_pwm10_gen;
    typedef struct {
        logic val;
        int   rq;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_out;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    pwm10_gen u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    always #5 clk = ~clk;

    // Monitor: one comparison per clock, just after the falling edge
    always @(negedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            n_chk++;
            if (pwm_out !== e.val) begin
                n_fail++;
                $display("FAIL R%0d: pwm_out=%b expected %b at %0t",
                         e.rq, pwm_out, e.val, $time);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // kind: 0 plain run, 1 upper-duty write at clock w, 2 stop write at clock w
    task automatic run_case(input int rq, input int per, input int d1,
                            input logic [1:0] psel, input int n,
                            input int kind, input int w, input int wval);
        int nm, len, d2;
        nm  = (psel == 2'b00) ? 1 : (psel == 2'b01) ? 4 : 16;
        len = (per + 1) * 4 * nm;
        d2  = (kind == 1) ? (wval * 4 + d1 % 4) : d1;
        wr(2'd2, 8'h00);
        wr(2'd0, 8'(per));
        wr(2'd1, 8'(d1 / 4));
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2;
        wr_data = 8'((d1 % 4) << 4) | 8'h04 | {6'b0, psel};
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        for (int k = 0; k < n; k++) begin
            int j, p, dj, r;
            logic v;
            j  = k / len;
            p  = k % len;
            r  = rq;
            dj = d1;
            if (kind == 1 && j > 0 && w < j * len) begin
                dj = d2;
                r  = 5;      // R5: new duty from the next period
            end
            v = (dj != 0) && (p < dj * nm);
            if (kind == 2 && k > w) begin
                v = 1'b0;
                r = 8;       // R8: forced low after stop write
            end
            q.push_back('{val: v, rq: r});
        end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (kind != 0 && k == w) begin
                wr_en   = 1'b1;
                wr_addr = (kind == 1) ? 2'd1 : 2'd2;
                wr_data = (kind == 1) ? 8'(wval) : 8'h00;
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: registers written but no enable, output must stay low
        for (int k = 0; k < 12; k++) q.push_back('{val: 1'b0, rq: 1});
        wr(2'd0, 8'd3);
        wr(2'd1, 8'h05);
        wr(2'd3, 8'hFF);
        repeat (8) @(negedge clk);
        // R2, R3: period 16 clocks, high 6
        run_case(3, 3, 6, 2'b00, 48, 0, 0, 0);
        // R2: period value 0 gives 4-clock periods
        run_case(2, 0, 2, 2'b00, 16, 0, 0, 0);
        // R4: prescale 4
        run_case(4, 2, 5, 2'b01, 96, 0, 0, 0);
        // R4: prescale 16 via select 11
        run_case(4, 1, 3, 2'b11, 256, 0, 0, 0);
        // R4: prescale 16 via select 10
        run_case(4, 1, 7, 2'b10, 128, 0, 0, 0);
        // R6: zero duty
        run_case(6, 3, 0, 2'b00, 32, 0, 0, 0);
        // R7: duty equal to and above the period length
        run_case(7, 3, 16, 2'b00, 32, 0, 0, 0);
        run_case(7, 3, 40, 2'b00, 32, 0, 0, 0);
        // R5: upper duty rewritten mid-period, 4 -> 12
        run_case(3, 3, 4, 2'b00, 48, 1, 5, 3);
        // R8: stop while output high
        run_case(7, 3, 20, 2'b00, 24, 2, 6, 0);
        // R9: duty carried only by the lower bits of the enabling write
        run_case(9, 3, 2, 2'b00, 32, 0, 0, 0);
        // R3: full-scale duty at the longest period
        run_case(3, 255, 1023, 2'b00, 2048, 0, 0, 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule